// File: doc/BRIEF.md
# SPI Host Command Frame Builder

This block sits between a host controller and an SPI bit shifter. The host gives it an opcode, a 24-bit address, a transfer size, a 32-bit write word and a CRC-disable flag, all with one `start` pulse. The block picks the header layout for that opcode and, unless CRC is disabled, appends a CRC7 trailer byte. It hands the frame to the shifter one byte at a time over a valid/ready byte stream. It then keeps the SPI transaction running with zero bytes, so the peripheral has room to return its response and, for register reads, its data. It raises `done` once the last of those bytes has been accepted.

The controller is a single state machine. Its states are IDLE (waiting for a start), HEADER (streaming header bytes while the CRC runs), TRAILER (presenting the CRC byte), FILL (streaming zero padding) and FINISH (a single cycle with `done` high). The transitions are: IDLE→HEADER on a start with a known opcode. HEADER→TRAILER after the last header byte is accepted when CRC is on, and HEADER→FILL when it is off. TRAILER→FILL when the trailer byte is accepted. FILL→FINISH when the last padding byte is accepted. FINISH→IDLE always.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset `out_valid`, `busy` and `done` are low.
- R2: A `start` in IDLE with a known opcode is accepted, and the opcode is on `out_byte` with `out_valid` high in the next cycle. The known opcodes are C1 (bulk write), C2 (bulk read), C3 (local reg write), C4 (local reg read), C5 (abort), C6 (retry), C7 (long bulk write), C8 (long bulk read), C9 (word write), CA (word read) and CF (peripheral reset), all hex. A `start` with any other opcode is ignored, and `busy` stays low.
- R3: Word read sends the opcode and then address bits 23:0, most significant byte first, for 4 header bytes. Word write sends the same bytes and then the 32-bit write word, most significant byte first, for 8 header bytes.
- R4: Local reg read sends the opcode, address bits 15:0 high byte first, and one zero byte, for 4 header bytes. Local reg write sends the opcode, address bits 15:0, and then the write word most significant byte first, for 7 header bytes.
- R5: Bulk read and bulk write send the opcode, the 3 address bytes and size bits 15:0, for 6 header bytes. The long bulk forms send the opcode, the 3 address bytes and size bits 23:0, for 7 header bytes. All fields go most significant byte first.
- R6: Abort, retry and peripheral reset send the opcode followed by three zero bytes.
- R7: With CRC enabled, the byte after the header is the CRC7 (polynomial x^7+x^3+1, register preset to 0x7F, header bits fed most significant bit first) of all header bytes, placed in bits 7:1 with bit 0 zero.
- R8: `crc_dis` high at the accepted start removes the trailer byte. The value `crc_dis` takes later in the transaction has no effect.
- R9: After the frame, zero bytes follow. There are 6 of them for abort, retry and reset, and 9 for word read and local reg read with CRC on (7 with CRC off). Every other opcode gets 5.
- R10: While `out_valid` is high and `out_ready` is low, `out_byte` holds. Each accepted byte advances the stream by exactly one byte.
- R11: `done` is high for exactly one cycle, the cycle after the last padding byte is accepted. `busy` is low in the cycle after that.
- R12: A `start` during a transaction is ignored, and the running frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command when idle |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Target address |
| xfer_size | input | 24 | Transfer size for bulk commands |
| wr_word | input | 32 | Write word for word and local-reg writes |
| crc_dis | input | 1 | Omit the CRC trailer, sampled at start |
| out_ready | input | 1 | Shifter accepts the byte on `out_byte` |
| out_valid | output | 1 | A byte is presented |
| out_byte | output | 8 | Stream byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The hardest cases to reach from the ports are at the phase boundaries: a stalled trailer byte, or a stalled last padding byte, while `crc_dis` or `start` changes underneath. The bench runs hundreds of random commands over every opcode. It drops `out_ready` at random with a varying probability, and in some runs it also pulses `start` with a different opcode and flips `crc_dis` after the start has been accepted. Every byte is compared with a frame that the bench builds itself, and the bench works out the CRC in a left-justified 8-bit form.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 24;
    localparam int SIZE_W    = 24;
    localparam int WORD_W    = 32;
    localparam int HDR_BYTES = 8;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;
    localparam int CNT_W     = 4;
    localparam int CRC_W     = 7;

    localparam logic [7:0] OP_BULK_WR  = 8'hC1;
    localparam logic [7:0] OP_BULK_RD  = 8'hC2;
    localparam logic [7:0] OP_LREG_WR  = 8'hC3;
    localparam logic [7:0] OP_LREG_RD  = 8'hC4;
    localparam logic [7:0] OP_ABORT    = 8'hC5;
    localparam logic [7:0] OP_RETRY    = 8'hC6;
    localparam logic [7:0] OP_LBULK_WR = 8'hC7;
    localparam logic [7:0] OP_LBULK_RD = 8'hC8;
    localparam logic [7:0] OP_WORD_WR  = 8'hC9;
    localparam logic [7:0] OP_WORD_RD  = 8'hCA;
    localparam logic [7:0] OP_PRESET   = 8'hCF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_TRAILER,
        ST_FILL,
        ST_FINISH
    } frame_state_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] xfer_size,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              crc_dis,
    output logic              known,
    output logic [HDR_W-1:0]  hdr,
    output logic [CNT_W-1:0]  hdr_len,
    output logic [CNT_W-1:0]  pad_len
);
    localparam logic [CNT_W-1:0] PAD_CTRL   = CNT_W'(6);
    localparam logic [CNT_W-1:0] PAD_PLAIN  = CNT_W'(5);
    localparam logic [CNT_W-1:0] PAD_RD_CRC = CNT_W'(9);
    localparam logic [CNT_W-1:0] PAD_RD_RAW = CNT_W'(7);

    always_comb begin
        known   = 1'b1;
        hdr     = '0;
        hdr_len = CNT_W'(4);
        pad_len = PAD_PLAIN;
        unique case (opcode)
            OP_WORD_RD: begin
                hdr     = {opcode, addr, 32'h0};
                hdr_len = CNT_W'(4);
                pad_len = crc_dis ? PAD_RD_RAW : PAD_RD_CRC;
            end
            OP_WORD_WR: begin
                hdr     = {opcode, addr, wr_word};
                hdr_len = CNT_W'(8);
            end
            OP_LREG_RD: begin
                hdr     = {opcode, addr[15:0], 8'h00, 32'h0};
                hdr_len = CNT_W'(4);
                pad_len = crc_dis ? PAD_RD_RAW : PAD_RD_CRC;
            end
            OP_LREG_WR: begin
                hdr     = {opcode, addr[15:0], wr_word, 8'h00};
                hdr_len = CNT_W'(7);
            end
            OP_BULK_WR, OP_BULK_RD: begin
                hdr     = {opcode, addr, xfer_size[15:0], 16'h0};
                hdr_len = CNT_W'(6);
            end
            OP_LBULK_WR, OP_LBULK_RD: begin
                hdr     = {opcode, addr, xfer_size, 8'h00};
                hdr_len = CNT_W'(7);
            end
            OP_ABORT, OP_RETRY, OP_PRESET: begin
                hdr     = {opcode, 56'h0};
                hdr_len = CNT_W'(4);
                pad_len = PAD_CTRL;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/spi_crc7_step.sv
module spi_crc7_step
    import spi_cmd_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] r;
        logic             fb;
        r = crc_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ data[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = r;
    end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_cmd_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_SEED = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [23:0]       addr,
    input  logic [23:0]       xfer_size,
    input  logic [31:0]       wr_word,
    input  logic              crc_dis,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              busy,
    output logic              done
);
    frame_state_t     state, state_nx;
    logic             known;
    logic [HDR_W-1:0] dec_hdr;
    logic [CNT_W-1:0] dec_hlen, dec_plen;
    logic [HDR_W-1:0] hdr_q;
    logic [CNT_W-1:0] hlen_q, plen_q, cnt_q;
    logic [CRC_W-1:0] crc_q, crc_nx;
    logic             crc_on_q;
    logic             accept, take, last_hdr, last_pad;

    spi_cmd_decode u_dec (
        .opcode    (opcode),
        .addr      (addr),
        .xfer_size (xfer_size),
        .wr_word   (wr_word),
        .crc_dis   (crc_dis),
        .known     (known),
        .hdr       (dec_hdr),
        .hdr_len   (dec_hlen),
        .pad_len   (dec_plen)
    );

    spi_crc7_step u_crc (
        .crc_in  (crc_q),
        .data    (hdr_q[HDR_W-1 -: BYTE_W]),
        .crc_out (crc_nx)
    );

    assign accept   = out_valid && out_ready;
    assign take     = (state == ST_IDLE) && start && known;
    assign last_hdr = (cnt_q == hlen_q - CNT_W'(1));
    assign last_pad = (cnt_q == plen_q - CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (take) state_nx = ST_HEADER;
            ST_HEADER:  if (accept && last_hdr) state_nx = crc_on_q ? ST_TRAILER : ST_FILL;
            ST_TRAILER: if (accept) state_nx = ST_FILL;
            ST_FILL:    if (accept && last_pad) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            hlen_q   <= '0;
            plen_q   <= '0;
            cnt_q    <= '0;
            crc_q    <= CRC_SEED;
            crc_on_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        hdr_q    <= dec_hdr;
                        hlen_q   <= dec_hlen;
                        plen_q   <= dec_plen;
                        crc_on_q <= !crc_dis;
                        crc_q    <= CRC_SEED;
                        cnt_q    <= '0;
                    end
                end
                ST_HEADER: begin
                    if (accept) begin
                        hdr_q <= {hdr_q[HDR_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                        crc_q <= crc_nx;
                        cnt_q <= last_hdr ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                ST_FILL: begin
                    if (accept) cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_byte  = '0;
        busy      = (state != ST_IDLE);
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HEADER: begin
                out_valid = 1'b1;
                out_byte  = hdr_q[HDR_W-1 -: BYTE_W];
            end
            ST_TRAILER: begin
                out_valid = 1'b1;
                out_byte  = {crc_q, 1'b0};
            end
            ST_FILL: out_valid = 1'b1;
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // R10
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && known) |=> (out_valid && out_byte == $past(opcode)));

    // R2
    unknown_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !known) |=> !busy);

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && out_valid && !out_ready && start) |=> $stable(out_byte));
endmodule

// File: tb/tb_spi_cmd_framer.sv
module tb_spi_cmd_framer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, start, crc_dis, out_ready;
    logic [7:0]  opcode;
    logic [23:0] addr, xfer_size;
    logic [31:0] wr_word;
    logic        out_valid, busy, done;
    logic [7:0]  out_byte;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_b [0:31];
    string      exp_t [0:31];
    int         exp_n;
    logic [7:0] got_b [0:31];
    int         got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_framer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
        .xfer_size(xfer_size), .wr_word(wr_word), .crc_dis(crc_dis),
        .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string t);
        exp_b[exp_n] = b;
        exp_t[exp_n] = t;
        exp_n++;
    endtask

    // CRC7 kept left-justified in 8 bits: polynomial 0x09 appears as 0x12
    function automatic logic [7:0] crc_of(input int n);
        logic [7:0] r;
        r = 8'hFE;
        for (int k = 0; k < n; k++) begin
            r = r ^ exp_b[k];
            for (int j = 0; j < 8; j++)
                r = r[7] ? ((r << 1) ^ 8'h12) : (r << 1);
        end
        return r;
    endfunction

    task automatic build_exp(input logic [7:0] op, input logic [23:0] a,
                             input logic [23:0] s, input logic [31:0] d, input bit cd);
        int npad;
        string t;
        exp_n = 0;
        npad = 5;
        case (op)
            8'hCA, 8'hC9: begin
                t = "R3";
                push(op, t); push(a[23:16], t); push(a[15:8], t); push(a[7:0], t);
                if (op == 8'hC9) begin
                    push(d[31:24], t); push(d[23:16], t); push(d[15:8], t); push(d[7:0], t);
                end else npad = cd ? 7 : 9;
            end
            8'hC4, 8'hC3: begin
                t = "R4";
                push(op, t); push(a[15:8], t); push(a[7:0], t);
                if (op == 8'hC3) begin
                    push(d[31:24], t); push(d[23:16], t); push(d[15:8], t); push(d[7:0], t);
                end else begin
                    push(8'h00, t); npad = cd ? 7 : 9;
                end
            end
            8'hC1, 8'hC2, 8'hC7, 8'hC8: begin
                t = "R5";
                push(op, t); push(a[23:16], t); push(a[15:8], t); push(a[7:0], t);
                if (op == 8'hC7 || op == 8'hC8) push(s[23:16], t);
                push(s[15:8], t); push(s[7:0], t);
            end
            default: begin
                t = "R6";
                push(op, t); push(8'h00, t); push(8'h00, t); push(8'h00, t);
                npad = 6;
            end
        endcase
        if (!cd) push(crc_of(exp_n), "R7");
        for (int k = 0; k < npad; k++) push(8'h00, "R9");
    endtask

    task automatic run_txn(input logic [7:0] op, input logic [23:0] a, input logic [23:0] s,
                           input logic [31:0] d, input bit cd, input int bp, input bit poke);
        int cyc;
        bit saw_done, held, hold_bad;
        logic [7:0] held_b;
        build_exp(op, a, s, d, cd);
        @(negedge clk);
        opcode = op; addr = a; xfer_size = s; wr_word = d; crc_dis = cd;
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(out_valid && out_byte == op, "R2", "first byte", {23'h0, out_valid, out_byte}, {24'h1, op});
        got_n = 0; cyc = 0; saw_done = 0; held = 0; hold_bad = 0; held_b = '0;
        while (!saw_done && cyc < 600) begin
            if (done) saw_done = 1;
            else begin
                if (held && (!out_valid || out_byte != held_b)) hold_bad = 1;
                if (poke && cyc == 2) begin
                    start = 1'b1; opcode = 8'hC9; crc_dis = ~cd; addr = ~a;
                end else start = 1'b0;
                if (out_valid) begin
                    out_ready = (int'($urandom % 100) >= bp);
                    if (out_ready && got_n < 32) begin
                        got_b[got_n] = out_byte;
                        got_n++;
                    end
                    held = !out_ready;
                    held_b = out_byte;
                end else begin
                    out_ready = 1'b0;
                    held = 0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0; out_ready = 1'b0;
        chk(saw_done, "R11", "done seen", 32'(saw_done), 32'h1);
        chk(!hold_bad, "R10", "byte held under stall", 32'(hold_bad), 32'h0);
        chk(got_n == exp_n, "R9", "frame length", 32'(got_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < got_n; k++)
            chk(got_b[k] == exp_b[k], exp_t[k], $sformatf("op %0h byte %0d", op, k),
                32'(got_b[k]), 32'(exp_b[k]));
        if (poke) chk(got_n == exp_n, "R12", "start while busy", 32'(got_n), 32'(exp_n));
        if (poke) chk(got_n == exp_n, "R8", "crc_dis change ignored", 32'(got_n), 32'(exp_n));
        @(negedge clk);
        chk(!done && !busy, "R11", "done one cycle", {30'h0, done, busy}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] ops [0:10];
        void'($urandom(32'h5EED_1234));
        ops = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
        rst_n = 1'b0; start = 1'b0; crc_dis = 1'b0; out_ready = 1'b0;
        opcode = '0; addr = '0; xfer_size = '0; wr_word = '0;
        repeat (3) @(negedge clk);
        // R1
        chk(!out_valid && !busy && !done, "R1", "reset state", {29'h0, out_valid, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !busy && !done, "R1", "after reset release", {29'h0, out_valid, busy, done}, 32'h0);

        // R2 unknown opcodes ignored
        foreach (ops[i]) begin end
        opcode = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !out_valid, "R2", "opcode 00 ignored", {30'h0, busy, out_valid}, 32'h0);
        opcode = 8'hCB; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !out_valid, "R2", "opcode CB ignored", {30'h0, busy, out_valid}, 32'h0);

        // directed corners: every opcode, both CRC settings, no stall and full address ones
        foreach (ops[i]) begin
            run_txn(ops[i], 24'hFFFFFF, 24'hFFFFFF, 32'hFFFF_FFFF, 1'b0, 0, 1'b0);
            run_txn(ops[i], 24'h001000, 24'h000000, 32'h0000_0000, 1'b1, 60, 1'b1);
        end

        // constrained random (R3 R4 R5 R6 R7 R8 R9 R10 R12)
        for (int n = 0; n < 300; n++) begin
            run_txn(ops[$urandom % 11], 24'($urandom), 24'($urandom), $urandom,
                    1'($urandom), int'($urandom % 70), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule